// File: doc/BRIEF.md
# Integer Add Execution Slice with Carry, Overflow and Condition Flags

This block is one execution slice of a 32-bit load/store processor pipeline. It covers the whole add family: the plain register sum, and a carrying sum that records its carry-out. It also covers an extended sum that feeds the stored carry back in, and two immediate forms whose 16-bit constant is sign-extended. The block holds the fixed-point exception state: a carry bit, an overflow bit and a sticky summary-overflow bit. It also holds a 4-bit condition field. Each variant updates only its own subset of these.

Decode supplies an opcode selector, the two register operands, the 16-bit immediate, and a flag saying that the first source index is zero. It also supplies the overflow-recording and condition-recording options, and a strobe that clears summary overflow. The result and all flag state are registered and appear one cycle after the issuing edge. A separate control module turns the opcode and options into strobes. The datapath module does the arithmetic and owns the state.

Top module: `int_add_unit`

## Requirements
- R1: After synchronous reset (rst high at a clock edge) the result, carry, overflow, summary overflow and condition field read zero.
- R2: Opcode 0 (plain add) loads result = opA + opB modulo 2^32 and leaves the carry bit unchanged.
- R3: Opcode 1 (carrying add) loads opA + opB and writes the carry-out of the 32-bit sum to the carry bit.
- R4: Opcode 2 (extended add) loads opA + opB + stored carry and writes the new carry-out to the carry bit.
- R5: Opcode 3 (add immediate) loads base + sign-extended imm, where base is zero when raZero is high and opA otherwise. Carry, overflow, summary overflow and the condition field stay unchanged whatever oeReq and rcReq say.
- R6: Opcode 4 (add immediate carrying) uses the same base and addend as R5 and writes the carry-out. With rcReq it updates the condition field. oeReq has no effect on it.
- R7: On opcodes 0 to 2 with oeReq high, the overflow bit takes the signed overflow of the sum: both addends share a sign and the result sign differs, with the carry-in included for opcode 2. Without oeReq the overflow bit is unchanged.
- R8: Summary overflow is set whenever an instruction records a set overflow. It is cleared only by soClear. If an overflow is recorded at the same edge as a clear, the bit ends set.
- R9: On a condition update, the 4-bit field is {negative, positive, zero, summary overflow}, with bit 3 as negative. The first three bits come from the signed result, and bit 0 is the summary-overflow value after this instruction. Without the condition option the field is unchanged.
- R10: With issue low, or with an opcode of 5 to 7, result, carry, overflow and condition field hold their values. Only soClear may still act.
- R11: Outputs change exactly one clock edge after the issuing edge, and they stay stable while nothing is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An instruction is presented this cycle |
| opSel | input | 3 | Operation selector (0 add, 1 carrying, 2 extended, 3 immediate, 4 immediate carrying) |
| opA | input | 32 | First source register value |
| opB | input | 32 | Second source register value |
| raZero | input | 1 | First source index is zero (immediate forms use literal zero) |
| imm | input | 16 | Signed immediate |
| oeReq | input | 1 | Overflow-recording option |
| rcReq | input | 1 | Condition-recording option |
| soClear | input | 1 | Clear summary overflow |
| result | output | 32 | Registered sum |
| carryQ | output | 1 | Stored carry bit |
| ovQ | output | 1 | Overflow bit |
| soQ | output | 1 | Sticky summary-overflow bit |
| condQ | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The assertions check the invariants on every cycle. A set overflow never appears without summary overflow, and summary overflow never drops without a clear. The condition field never holds more than one of negative, positive and zero. Idle cycles and forms that do not write the carry leave the state untouched. The arithmetic cannot be seen from those invariants. This includes the carry-out and signed overflow values, the literal-zero base for immediate forms, sign extension of the immediate, and the carry chain between successive extended adds. Only the bench's sweeps over corner operands such as 0x7FFFFFFF+1, 0xFFFFFFFF+1 and an overflow caused by the carry-in can show these, using a running model of the flag state.

// File: rtl/int_add_pkg.sv
package int_add_pkg;

  localparam logic [2:0] OP_ADD   = 3'd0;
  localparam logic [2:0] OP_ADDC  = 3'd1;
  localparam logic [2:0] OP_ADDE  = 3'd2;
  localparam logic [2:0] OP_ADDI  = 3'd3;
  localparam logic [2:0] OP_ADDIC = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new result
    logic useImm;    // second addend is the extended immediate
    logic zeroBase;  // first addend forced to zero
    logic carryIn;   // stored carry joins the sum
    logic wrCa;      // record carry-out
    logic wrOvSo;    // record overflow and summary overflow
    logic wrCr;      // record condition field
  } addStrobe_t;

endpackage

// File: rtl/int_add_ctrl.sv
module int_add_ctrl
  import int_add_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        issue,
  input  logic [2:0]  opSel,
  input  logic        raZero,
  input  logic        oeReq,
  input  logic        rcReq,
  output addStrobe_t  strb
);

  always_comb begin
    strb = '0;
    if (issue) begin
      unique case (opSel)
        OP_ADD: begin
          strb.load   = 1'b1;
          strb.wrOvSo = oeReq;
          strb.wrCr   = rcReq;
        end
        OP_ADDC: begin
          strb.load   = 1'b1;
          strb.wrCa   = 1'b1;
          strb.wrOvSo = oeReq;
          strb.wrCr   = rcReq;
        end
        OP_ADDE: begin
          strb.load    = 1'b1;
          strb.carryIn = 1'b1;
          strb.wrCa    = 1'b1;
          strb.wrOvSo  = oeReq;
          strb.wrCr    = rcReq;
        end
        OP_ADDI: begin
          strb.load     = 1'b1;
          strb.useImm   = 1'b1;
          strb.zeroBase = raZero;
        end
        OP_ADDIC: begin
          strb.load     = 1'b1;
          strb.useImm   = 1'b1;
          strb.zeroBase = raZero;
          strb.wrCa     = 1'b1;
          strb.wrCr     = rcReq;
        end
        default: strb = '0;
      endcase
    end
  end

  // R5
  imm_quiet_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && opSel == OP_ADDI) |-> !(strb.wrCa || strb.wrOvSo || strb.wrCr));

  // R6
  immc_no_ov_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && opSel == OP_ADDIC) |-> (strb.wrCa && !strb.wrOvSo));

  // R10
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!issue || opSel > OP_ADDIC) |-> (strb == '0));

endmodule

// File: rtl/int_add_datapath.sv
module int_add_datapath
  import int_add_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  addStrobe_t        strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic              soClear,
  output logic [DATA_W-1:0] resultQ,
  output logic              carryQ,
  output logic              ovQ,
  output logic              soQ,
  output logic [3:0]        condQ
);

  localparam int EXT_W = DATA_W - IMM_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] baseOp;
  logic [DATA_W-1:0] addendOp;
  logic              cinBit;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sumVal;
  logic              sumCarry;
  logic              sumOv;
  logic              soNext;
  logic [3:0]        condNext;

  assign immExt   = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign baseOp   = strb.zeroBase ? '0 : opA;
  assign addendOp = strb.useImm ? immExt : opB;
  assign cinBit   = strb.carryIn & carryQ;

  assign sumWide  = {1'b0, baseOp} + {1'b0, addendOp} + {{DATA_W{1'b0}}, cinBit};
  assign sumVal   = sumWide[MSB:0];
  assign sumCarry = sumWide[DATA_W];
  assign sumOv    = (baseOp[MSB] == addendOp[MSB]) && (sumVal[MSB] != baseOp[MSB]);

  // clear first, then a recorded overflow may set it again
  assign soNext = (soQ & ~soClear) | (strb.wrOvSo & sumOv);

  assign condNext = {sumVal[MSB],
                     ~sumVal[MSB] & (sumVal != '0),
                     (sumVal == '0),
                     soNext};

  always_ff @(posedge clk) begin
    if (rst) begin
      resultQ <= '0;
      carryQ  <= 1'b0;
      ovQ     <= 1'b0;
      soQ     <= 1'b0;
      condQ   <= '0;
    end else begin
      soQ <= soNext;
      if (strb.load)   resultQ <= sumVal;
      if (strb.wrCa)   carryQ  <= sumCarry;
      if (strb.wrOvSo) ovQ     <= sumOv;
      if (strb.wrCr)   condQ   <= condNext;
    end
  end

  // R2
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.wrCa |=> $stable(carryQ));

  // R8
  so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (soQ && !soClear) |=> soQ);

  // R8
  ov_sets_so_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovQ) |-> soQ);

  // R9
  cond_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(condQ[3:1]));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(resultQ));

  // R7
  ov_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.wrOvSo |=> $stable(ovQ));

endmodule

// File: rtl/int_add_unit.sv
module int_add_unit
  import int_add_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              raZero,
  input  logic [IMM_W-1:0]  imm,
  input  logic              oeReq,
  input  logic              rcReq,
  input  logic              soClear,
  output logic [DATA_W-1:0] result,
  output logic              carryQ,
  output logic              ovQ,
  output logic              soQ,
  output logic [3:0]        condQ
);

  addStrobe_t strb;

  int_add_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .issue  (issue),
    .opSel  (opSel),
    .raZero (raZero),
    .oeReq  (oeReq),
    .rcReq  (rcReq),
    .strb   (strb)
  );

  int_add_datapath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .opA     (opA),
    .opB     (opB),
    .imm     (imm),
    .soClear (soClear),
    .resultQ (result),
    .carryQ  (carryQ),
    .ovQ     (ovQ),
    .soQ     (soQ),
    .condQ   (condQ)
  );

endmodule

// File: tb/int_add_unit_tb.sv
module int_add_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue;
  logic [2:0]  opSel;
  logic [31:0] opA, opB;
  logic        raZero;
  logic [15:0] imm;
  logic        oeReq, rcReq, soClear;
  logic [31:0] result;
  logic        carryQ, ovQ, soQ;
  logic [3:0]  condQ;

  int vecCnt  = 0;
  int missCnt = 0;
  bit done    = 1'b0;

  // running model of architectural state
  logic [31:0] mRes;
  logic        mCa, mOv, mSo;
  logic [3:0]  mCr;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_add_unit u_dut (
    .clk(clk), .rst(rst), .issue(issue), .opSel(opSel), .opA(opA), .opB(opB),
    .raZero(raZero), .imm(imm), .oeReq(oeReq), .rcReq(rcReq), .soClear(soClear),
    .result(result), .carryQ(carryQ), .ovQ(ovQ), .soQ(soQ), .condQ(condQ)
  );

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic compare(input string tag);
    vecCnt++;
    if ({result, carryQ, ovQ, soQ, condQ} !== {mRes, mCa, mOv, mSo, mCr}) begin
      missCnt++;
      $display("FAIL %s: actual res=%h ca=%b ov=%b so=%b cr=%b expected res=%h ca=%b ov=%b so=%b cr=%b",
               tag, result, carryQ, ovQ, soQ, condQ, mRes, mCa, mOv, mSo, mCr);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic apply(input bit iss, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input bit rz, input logic [15:0] im,
                       input bit oe, input bit rc, input bit clr, input string phase);
    logic [31:0] base, addend, sum;
    logic [32:0] wide;
    logic        cin, ov;
    bit          isImm, isReg, valid;
    issue = iss; opSel = op; opA = a; opB = b; raZero = rz; imm = im;
    oeReq = oe; rcReq = rc; soClear = clr;
    valid  = iss && (op <= 3'd4);
    isImm  = (op == 3'd3) || (op == 3'd4);
    isReg  = (op <= 3'd2);
    base   = (isImm && rz) ? 32'd0 : a;
    addend = isImm ? {{16{im[15]}}, im} : b;
    cin    = (op == 3'd2) ? mCa : 1'b0;
    wide   = {1'b0, base} + {1'b0, addend} + {32'd0, cin};
    sum    = wide[31:0];
    ov     = (base[31] == addend[31]) && (sum[31] != base[31]);
    if (clr) mSo = 1'b0;
    if (valid) begin
      mRes = sum;
      if (op == 3'd1 || op == 3'd2 || op == 3'd4) mCa = wide[32];
      if (isReg && oe) begin
        mOv = ov;
        if (ov) mSo = 1'b1;
      end
      if (rc && (isReg || op == 3'd4))
        mCr = {sum[31], !sum[31] && (sum != 0), sum == 0, mSo};
    end
    @(negedge clk);
    compare({phase, " ", iss ? opTag(op) : "R10"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      missCnt++;
      $display("FAIL R11: watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [8];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
    corner[4] = 32'hFFFF_FFFF; corner[5] = 32'hFFFF_FFFE;
    corner[6] = 32'h5555_5555; corner[7] = 32'h8000_0001;

    rst = 1'b1; issue = 0; opSel = 0; opA = 0; opB = 0; raZero = 0; imm = 0;
    oeReq = 0; rcReq = 0; soClear = 0;
    mRes = 0; mCa = 0; mOv = 0; mSo = 0; mCr = 0;
    // R1: dirty inputs during reset must not leak
    @(negedge clk); issue = 1; opA = 32'hFFFF_FFFF; opB = 1; oeReq = 1; rcReq = 1;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst = 1'b0;

    // named corners: R7 0x7FFFFFFF+1 overflows, R3 0xFFFFFFFF+1 carries
    apply(1, 3'd0, 32'h7FFF_FFFF, 32'h1, 0, 0, 1, 1, 0, "R7 R9 max+1");
    apply(1, 3'd1, 32'hFFFF_FFFF, 32'h1, 0, 0, 1, 1, 0, "R3 R9 wrap");
    // R4 R7: carry-in alone pushes 0x7FFFFFFF+0 over the signed limit
    apply(1, 3'd2, 32'h7FFF_FFFF, 32'h0, 0, 0, 1, 1, 1, "R4 R7 cin-ov");
    // R8: same-edge clear and overflow leaves summary set
    apply(1, 3'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 1, 1, 1, "R8 clr+ov");
    apply(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, "R8 idle");
    apply(0, 3'd0, 0, 0, 0, 0, 0, 0, 1, "R8 clear");
    // R5: immediate with zero base, sign extension, options ignored
    apply(1, 3'd3, 32'h1234_5678, 0, 1, 16'h8000, 1, 1, 0, "R5 zero-base");
    apply(1, 3'd3, 32'h1234_5678, 0, 0, 16'hFFFF, 1, 1, 0, "R5 reg-base");
    // R6: immediate carrying with record, oe ignored
    apply(1, 3'd4, 32'hFFFF_FFFF, 0, 0, 16'h0001, 1, 1, 0, "R6 R9 rc");
    // R10: undefined opcode and idle hold state
    apply(1, 3'd6, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 1, 1, 0, "R10 undef");
    apply(0, 3'd2, 32'hDEAD_BEEF, 32'h1, 0, 0, 1, 1, 0, "R10 R11 idle");

    // sweep: every opcode, corner pair, option combination and zero-base flag
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int f = 0; f < 8; f++)
            apply(1, 3'(op), corner[i], corner[j], f[2], corner[j][15:0] ^ corner[i][31:16],
                  f[0], f[1], (i == 5 && j == 0), "sweep");

    // random operands across all variants, occasional idle and clear
    for (int k = 0; k < 3000; k++)
      apply(($urandom % 8) != 0, 3'($urandom % 6), $urandom, $urandom, $urandom % 2,
            16'($urandom), $urandom % 2, $urandom % 2, ($urandom % 16) == 0, "R7 R9 random");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule